// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block keeps the exclusive reservations that pair a load-linked with a later store-conditional for one requesting context. Reservations are held per cache line. Each one sits in a small, fully associative table and carries the identifier of the context that owns it. A single event port delivers one event per cycle, each with a byte address. The events are load-linked, plain store, forced-fail write, store-conditional, eviction and clear-all. With each event, the surrounding cache supplies a same-cycle flag that says whether the event's line is resident. Each store-conditional gets a one-bit pass or fail result one cycle later. Each eviction is passed downstream one cycle later, after its reservation has been dropped.

A separate query port answers, combinationally, whether a byte address falls in a line that this context holds reserved. A line address is the byte address with its low log2(LINE_BYTES) bits ignored.

The event port uses a valid/ready handshake. Ready is held high at all times, so an event is taken on every cycle where valid is high and there is no back-pressure. The store-conditional result and the eviction output are plain one-cycle pulses with no ready signal. Whatever receives them must capture them in the cycle they appear.

Top module: `llsc_monitor`

## Requirements
- R1: A load-linked (kind 3'd1) to a resident line, when this context holds no reservation on that line, records a reservation tagged with `ctx_id`. The query port reports it from the next cycle on. A load-linked to a line this context already holds changes nothing.
- R2: A load-linked whose line is not resident records nothing, and the table is unchanged.
- R3: A plain store (kind 3'd2) or a forced-fail write (kind 3'd6) removes this context's reservation on its line. On a line this context does not hold, it has no effect.
- R4: A store-conditional (kind 3'd3) to a resident line that this context holds passes. `sc_done` pulses in the next cycle with `sc_pass` = 1, and the reservation is removed.
- R5: A store-conditional fails (`sc_pass` = 0 on the next-cycle `sc_done` pulse) when its line is not resident or is not held by this context. In either case, any reservation this context holds on that line is removed.
- R6: An eviction (kind 3'd4) removes every reservation on its line, whatever its tag. In the next cycle it raises `evict_out_valid` with `evict_out_addr` set to the line-aligned address.
- R7: A clear-all (kind 3'd5) removes every reservation tagged with the current `ctx_id` and keeps reservations tagged otherwise.
- R8: The query and event ports compare line addresses only. The low log2(LINE_BYTES) address bits (6 by default) never change a result.
- R9: The table holds ENTRIES reservations (8 by default). A load-linked that needs a slot while all slots are full replaces the entry that was recorded earliest.
- R10: Queries, stores and store-conditionals only match reservations whose tag equals the present `ctx_id`.
- R11: `evt_ready` is always 1. Nothing happens when `evt_valid` is 0, and kinds 3'd0 and 3'd7 are ignored.
- R12: While `rst_n` is low, the table is emptied and `sc_done`, `evict_out_valid` and `chk_reserved` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_id | input | CW | Identifier of the owning context |
| evt_valid | input | 1 | Event present |
| evt_ready | output | 1 | Event accepted (always 1) |
| evt_kind | input | 3 | Event kind code |
| evt_addr | input | AW | Event byte address |
| line_resident | input | 1 | Event's line is resident in the data cache |
| sc_done | output | 1 | Store-conditional result pulse |
| sc_pass | output | 1 | Store-conditional succeeded |
| evict_out_valid | output | 1 | Eviction forwarded downstream |
| evict_out_addr | output | AW | Line-aligned address of forwarded eviction |
| chk_addr | input | AW | Query byte address |
| chk_reserved | output | 1 | Query line reserved by `ctx_id` |

## Verification
The table changes at the clock edge that accepts an event, so a query that names that line shows the new state in the same cycle's second half. The `sc_done`/`sc_pass` and `evict_out_*` registers become valid exactly one edge after the event. The bench drives on the falling edge and compares every output at the next falling edge against a queue-based model that was updated when the stimulus was applied. Each result is therefore checked exactly one clock after its cause, and each check names the requirement of that cause.

// File: rtl/llsc_mon_pkg.sv
package llsc_mon_pkg;
  typedef enum logic [2:0] {
    EV_IDLE   = 3'd0,
    EV_LL     = 3'd1,
    EV_ST     = 3'd2,
    EV_SC     = 3'd3,
    EV_EVICT  = 3'd4,
    EV_CLRALL = 3'd5,
    EV_STFAIL = 3'd6,
    EV_RSVD   = 3'd7
  } ev_kind_e;
endpackage

// File: rtl/llsc_mon_slot.sv
module llsc_mon_slot #(
  parameter int LW = 26,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          clr,
  input  logic [LW-1:0] ld_line,
  input  logic [CW-1:0] own_tag,
  input  logic [LW-1:0] evt_line,
  input  logic [LW-1:0] chk_line,
  output logic          vld,
  output logic          own_evt,
  output logic          any_evt,
  output logic          own_chk,
  output logic          mine
);
  logic [LW-1:0] line_q;
  logic [CW-1:0] tag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= 1'b0;
      line_q <= '0;
      tag_q  <= '0;
    end else if (load) begin
      vld    <= 1'b1;
      line_q <= ld_line;
      tag_q  <= own_tag;
    end else if (clr) begin
      vld <= 1'b0;
    end
  end

  assign mine    = vld && (tag_q == own_tag);
  assign any_evt = vld && (line_q == evt_line);
  assign own_evt = any_evt && (tag_q == own_tag);
  assign own_chk = mine && (line_q == chk_line);

  p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !load) |=> !vld);
endmodule

// File: rtl/llsc_mon_victim.sv
module llsc_mon_victim #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  vld,
  input  logic          take,
  output logic [IW-1:0] slot
);
  // older[i][j] set: entry i was recorded before entry j
  logic [N-1:0] older [N];
  logic [N-1:0] is_oldest;
  logic         found;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      is_oldest[i] = vld[i];
      for (int j = 0; j < N; j++)
        if (j != i && vld[j] && !older[i][j]) is_oldest[i] = 1'b0;
    end
    slot  = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++)
      if (!found && !vld[i]) begin
        slot  = IW'(i);
        found = 1'b1;
      end
    for (int i = 0; i < N; i++)
      if (!found && is_oldest[i]) begin
        slot  = IW'(i);
        found = 1'b1;
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) older[i] <= '0;
    end else if (take) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (i == int'(slot)) older[i][j] <= 1'b0;
          else if (j == int'(slot)) older[i][j] <= 1'b1;
    end
  end

  generate
    for (genvar gi = 0; gi < N; gi++) begin : g_row
      for (genvar gj = gi + 1; gj < N; gj++) begin : g_col
        p_order_total_r9: assert property (@(posedge clk) disable iff (!rst_n)
          (vld[gi] && vld[gj]) |-> (older[gi][gj] != older[gj][gi]));
      end
    end
  endgenerate
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_mon_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 4,
  parameter int LINE_BYTES = 64,
  parameter int ENTRIES    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ctx_id,
  input  logic          evt_valid,
  output logic          evt_ready,
  input  logic [2:0]    evt_kind,
  input  logic [AW-1:0] evt_addr,
  input  logic          line_resident,
  output logic          sc_done,
  output logic          sc_pass,
  output logic          evict_out_valid,
  output logic [AW-1:0] evict_out_addr,
  input  logic [AW-1:0] chk_addr,
  output logic          chk_reserved
);
  localparam int OFFW = $clog2(LINE_BYTES);
  localparam int LW   = AW - OFFW;
  localparam int IW   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  ev_kind_e      kind;
  logic [LW-1:0] evt_line, chk_line;
  logic [ENTRIES-1:0] vld, own_hit, any_hit, own_chk, mine, load, clr;
  logic [IW-1:0] slot;
  logic          is_ll, is_wr, is_sc, is_ev, is_ca, take;

  assign evt_ready = 1'b1;
  assign kind      = ev_kind_e'(evt_kind);
  assign evt_line  = evt_addr[AW-1:OFFW];
  assign chk_line  = chk_addr[AW-1:OFFW];

  assign is_ll = evt_valid && (kind == EV_LL);
  assign is_wr = evt_valid && (kind == EV_ST || kind == EV_STFAIL);
  assign is_sc = evt_valid && (kind == EV_SC);
  assign is_ev = evt_valid && (kind == EV_EVICT);
  assign is_ca = evt_valid && (kind == EV_CLRALL);
  assign take  = is_ll && line_resident && !(|own_hit);

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      assign load[g] = take && (slot == IW'(g));
      assign clr[g]  = ((is_wr || is_sc) && own_hit[g]) ||
                       (is_ev && any_hit[g]) || (is_ca && mine[g]);
      llsc_mon_slot #(.LW(LW), .CW(CW)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load[g]),
        .clr     (clr[g]),
        .ld_line (evt_line),
        .own_tag (ctx_id),
        .evt_line(evt_line),
        .chk_line(chk_line),
        .vld     (vld[g]),
        .own_evt (own_hit[g]),
        .any_evt (any_hit[g]),
        .own_chk (own_chk[g]),
        .mine    (mine[g])
      );
    end
  endgenerate

  llsc_mon_victim #(.N(ENTRIES), .IW(IW)) u_victim (
    .clk  (clk),
    .rst_n(rst_n),
    .vld  (vld),
    .take (take),
    .slot (slot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_done         <= 1'b0;
      sc_pass         <= 1'b0;
      evict_out_valid <= 1'b0;
      evict_out_addr  <= '0;
    end else begin
      sc_done         <= is_sc;
      sc_pass         <= is_sc && line_resident && (|own_hit);
      evict_out_valid <= is_ev;
      if (is_ev) evict_out_addr <= {evt_line, {OFFW{1'b0}}};
    end
  end

  assign chk_reserved = |own_chk;

  p_one_owner_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(own_hit));
  p_absent_ll_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ll && !line_resident) |=> ($countones(vld) == $past($countones(vld))));
  p_done_after_sc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done |-> $past(is_sc));
  p_pass_resident_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sc_pass |-> $past(line_resident && is_sc));
  p_evict_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evict_out_valid |-> $past(is_ev));
  p_ready_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ready);
endmodule

// File: tb/llsc_monitor_test.sv
module llsc_monitor_test;
  localparam int AW = 32, CW = 4, OFF = 6, DEPTH = 8;

  typedef struct { int line; int tag; } rsv_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] ctx_id = 4'd3;
  logic          evt_valid = 1'b0;
  logic          evt_ready;
  logic [2:0]    evt_kind = 3'd0;
  logic [AW-1:0] evt_addr = '0;
  logic          line_resident = 1'b0;
  logic          sc_done, sc_pass, evict_out_valid, chk_reserved;
  logic [AW-1:0] evict_out_addr;
  logic [AW-1:0] chk_addr = '0;

  int n_chk = 0, n_fail = 0;
  rsv_t mq[$];
  bit exp_rv = 0, exp_rp = 0, exp_ev = 0;
  logic [AW-1:0] exp_ea = '0;
  string cur_req = "R12";
  bit done = 0;

  always #4 clk = ~clk;

  llsc_monitor #(.AW(AW), .CW(CW), .LINE_BYTES(64), .ENTRIES(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .ctx_id(ctx_id), .evt_valid(evt_valid),
    .evt_ready(evt_ready), .evt_kind(evt_kind), .evt_addr(evt_addr),
    .line_resident(line_resident), .sc_done(sc_done), .sc_pass(sc_pass),
    .evict_out_valid(evict_out_valid), .evict_out_addr(evict_out_addr),
    .chk_addr(chk_addr), .chk_reserved(chk_reserved)
  );

  task automatic expect_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit model_has(int ln, int tg);
    foreach (mq[i]) if (mq[i].line == ln && mq[i].tag == tg) return 1;
    return 0;
  endfunction

  task automatic compare();
    expect_eq(cur_req, "evt_ready", evt_ready, 1);
    expect_eq(cur_req, "sc_done", sc_done, exp_rv);
    if (exp_rv) expect_eq(cur_req, "sc_pass", sc_pass, exp_rp);
    expect_eq(cur_req, "evict_out_valid", evict_out_valid, exp_ev);
    if (exp_ev) expect_eq(cur_req, "evict_out_addr", evict_out_addr, exp_ea);
    expect_eq(cur_req, "chk_reserved", chk_reserved,
              model_has(int'(chk_addr >> OFF), int'(ctx_id)));
  endtask

  // one cycle: check previous results, then drive and update the model
  task automatic step(string req, bit v, bit [2:0] k, int ln, int off,
                      bit res, int cln, int ctx);
    int tg;
    bit hit;
    @(negedge clk);
    compare();
    cur_req = req;
    ctx_id = CW'(ctx);
    evt_valid = v;
    evt_kind = k;
    evt_addr = AW'(ln * 64 + off);
    line_resident = res;
    chk_addr = AW'(cln * 64 + ((ln * 7 + off) % 64));
    exp_rv = 0; exp_ev = 0;
    tg = ctx;
    hit = model_has(ln, tg);
    if (v) begin
      case (k)
        3'd1: if (res && !hit) begin
                if (mq.size() == DEPTH) mq.delete(0);
                mq.push_back('{line: ln, tag: tg});
              end
        3'd2, 3'd6: begin
          for (int i = mq.size() - 1; i >= 0; i--)
            if (mq[i].line == ln && mq[i].tag == tg) mq.delete(i);
        end
        3'd3: begin
          exp_rv = 1;
          exp_rp = res && hit;
          for (int i = mq.size() - 1; i >= 0; i--)
            if (mq[i].line == ln && mq[i].tag == tg) mq.delete(i);
        end
        3'd4: begin
          exp_ev = 1;
          exp_ea = AW'(ln * 64);
          for (int i = mq.size() - 1; i >= 0; i--)
            if (mq[i].line == ln) mq.delete(i);
        end
        3'd5: begin
          for (int i = mq.size() - 1; i >= 0; i--)
            if (mq[i].tag == tg) mq.delete(i);
        end
        default: ;
      endcase
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_eq("R12", "sc_done in reset", sc_done, 0);
    expect_eq("R12", "evict_out_valid in reset", evict_out_valid, 0);
    expect_eq("R12", "chk_reserved in reset", chk_reserved, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1, R8: reserve line 1, query with a different byte offset
    step("R1", 1, 3'd1, 1, 5, 1, 1, 3);
    step("R8", 0, 3'd0, 1, 63, 0, 1, 3);
    // R2: absent line is not recorded
    step("R2", 1, 3'd1, 2, 0, 0, 2, 3);
    // R3: store to unreserved line, then store to reserved line
    step("R3", 1, 3'd2, 5, 0, 1, 1, 3);
    step("R3", 1, 3'd2, 1, 9, 1, 1, 3);
    step("R3", 1, 3'd1, 1, 0, 1, 1, 3);
    step("R3", 1, 3'd6, 1, 40, 1, 1, 3);
    // R4, R5: pass then fail on same line
    step("R1", 1, 3'd1, 1, 0, 1, 1, 3);
    step("R4", 1, 3'd3, 1, 8, 1, 1, 3);
    step("R5", 1, 3'd3, 1, 8, 1, 1, 3);
    // R5: non-resident store-conditional still clears
    step("R1", 1, 3'd1, 3, 0, 1, 3, 3);
    step("R5", 1, 3'd3, 3, 0, 0, 3, 3);
    // R6: eviction clears and forwards
    step("R1", 1, 3'd1, 4, 0, 1, 4, 3);
    step("R6", 1, 3'd4, 4, 17, 1, 4, 3);
    // R7, R10: two contexts
    step("R1", 1, 3'd1, 6, 0, 1, 6, 3);
    step("R1", 1, 3'd1, 7, 0, 1, 7, 3);
    step("R10", 1, 3'd1, 6, 0, 1, 6, 5);
    step("R10", 1, 3'd3, 7, 0, 1, 7, 5);
    step("R10", 0, 3'd0, 0, 0, 0, 7, 3);
    step("R7", 1, 3'd5, 0, 0, 1, 6, 5);
    step("R7", 0, 3'd0, 0, 0, 0, 6, 3);
    step("R6", 1, 3'd1, 6, 0, 1, 6, 5);
    step("R6", 1, 3'd4, 6, 0, 1, 6, 3);
    step("R6", 0, 3'd0, 0, 0, 0, 6, 5);
    // R9: overfill the table
    for (int i = 0; i < 10; i++) step("R9", 1, 3'd1, 20 + i, 0, 1, 20, 3);
    step("R9", 0, 3'd0, 0, 0, 0, 21, 3);
    step("R9", 0, 3'd0, 0, 0, 0, 22, 3);
    step("R9", 0, 3'd0, 0, 0, 0, 29, 3);
    // R11: ignored kinds and idle valid
    step("R11", 1, 3'd7, 22, 0, 1, 22, 3);
    step("R11", 1, 3'd0, 22, 0, 1, 22, 3);
    step("R11", 0, 3'd3, 22, 0, 1, 22, 3);
    step("R11", 0, 3'd4, 23, 0, 1, 23, 3);
    // mixed traffic
    for (int n = 0; n < 4000; n++) begin
      int k = $urandom_range(0, 9);
      int ln = $urandom_range(1, 12);
      int ctx = ($urandom_range(0, 15) == 0) ? 5 : 3;
      step("R4", $urandom_range(0, 5) != 0, (k > 7) ? 3'd1 : 3'(k), ln,
           $urandom_range(0, 63), $urandom_range(0, 3) != 0,
           $urandom_range(1, 12), ctx);
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule